// File: doc/BRIEF.md
# Single-Channel DMA Controller with Cycle Stealing

This block moves a block of words between one peripheral and memory without the processor touching each word. Software sets up four values through a small write-only register port: the transfer direction, the peripheral's device address, the first memory address and the number of words. It then writes a launch bit. From that point the engine moves one word per memory cycle. The memory address steps up by one and the remaining count steps down by one after each word. When the count runs out, the engine raises an interrupt.

The engine shares the memory bus with the CPU through an arbiter in which the engine always wins. Two ownership modes are chosen at launch. In stop-CPU (burst) mode the engine holds the bus for the whole block, and the CPU is locked out even while the peripheral stalls. In cycle-stealing mode the engine asks for the bus only in a cycle where the peripheral can supply or accept a word. It gives the bus back straight after that word. Memory reads are modelled as combinational, so a memory-to-device word is read from memory and handed to the device in the same cycle.

Top module: `dma_cs_engine`

## Requirements
- R1: After reset `busy`, `irq`, `mem_en`, `dma_gnt`, `dev_ack` and `dev_wr` are low, and `cpu_gnt` equals `cpu_req`.
- R2: The register port decodes `reg_addr` as follows: 0 is control, 1 is device address, 2 is memory start, 3 is word count and 4 is status. In the control word, bit 0 is launch, bit 1 is direction (0 = device to memory, 1 = memory to device) and bit 2 is mode (0 = cycle stealing, 1 = stop-CPU). A launch with a nonzero count sets `busy` on the edge that takes the write.
- R3: For device-to-memory transfers, each cycle with `dev_rdy` high and the engine busy writes `dev_rdata` to `mem_addr` (`mem_en`=1, `mem_we`=1) and pulses `dev_ack`. The address then advances by one.
- R4: For memory-to-device transfers, each cycle with `dev_room` high and the engine busy reads `mem_addr` (`mem_en`=1, `mem_we`=0) and pulses `dev_wr` with `dev_wdata` equal to `mem_rdata`. The address then advances by one.
- R5: On the edge that moves the last word, `busy` falls and `irq` rises. No further memory access follows.
- R6: `irq` stays high until a write to the status register clears it. If a completion and a status write fall in the same cycle, the completion wins.
- R7: A launch with a word count of zero sets `irq` on the next edge without ever raising `busy` or making a memory access.
- R8: While `busy` is high, writes to the control, device, memory-start and count registers are ignored. Running transfers keep their direction, address and length.
- R9: When the engine and the CPU want the bus in the same cycle, `dma_gnt` is high and `cpu_gnt` is low.
- R10: In cycle-stealing mode, the engine requests the bus only in cycles where the peripheral is ready. In all other cycles `dma_gnt` is low and `cpu_gnt` follows `cpu_req`.
- R11: In stop-CPU mode, `dma_gnt` is high and `cpu_gnt` is low in every busy cycle, even while the peripheral stalls. The bus returns to the CPU once `busy` falls.
- R12: `dev_sel` drives the device address most recently written while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| busy | output | 1 | Block transfer in progress |
| irq | output | 1 | Completion interrupt |
| cpu_req | input | 1 | CPU wants the memory bus |
| cpu_gnt | output | 1 | CPU owns the memory bus this cycle |
| dma_gnt | output | 1 | Engine owns the memory bus this cycle |
| mem_en | output | 1 | Engine memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | MADDR_W | Current memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data (combinational) |
| dev_sel | output | DEV_W | Selected peripheral address |
| dev_rdy | input | 1 | Peripheral has a word for the engine |
| dev_rdata | input | DATA_W | Word from the peripheral |
| dev_ack | output | 1 | Engine took the peripheral's word |
| dev_room | input | 1 | Peripheral can accept a word |
| dev_wr | output | 1 | Engine hands a word to the peripheral |
| dev_wdata | output | DATA_W | Word to the peripheral |

## Verification
The cycle that is easiest to get wrong is one where the CPU asks for the bus while the engine moves a word. The bench holds `cpu_req` high through a cycle-stealing block and alternates peripheral-ready cycles with stall cycles. It expects `cpu_gnt` to drop exactly in the word cycles and to return in the stall cycles. A second collision puts a status-register write into the same cycle as the final word. The bench then expects `irq` to end that cycle set rather than cleared.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;

   // register select codes on the write port
   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_DEV  = 3'd1,
      REG_MEM  = 3'd2,
      REG_CNT  = 3'd3,
      REG_STAT = 3'd4
   } reg_sel_e;

   // control word bit positions
   localparam int CTRL_GO    = 0;
   localparam int CTRL_DIR   = 1;
   localparam int CTRL_BURST = 2;
   localparam int CTRL_W     = 3;

   typedef enum logic {
      DIR_DEV2MEM = 1'b0,
      DIR_MEM2DEV = 1'b1
   } dir_e;

   typedef enum logic {
      MODE_STEAL = 1'b0,
      MODE_BURST = 1'b1
   } mode_e;

endpackage

// File: rtl/dma_cs_counter.sv
module dma_cs_counter #(
   parameter int W  = 16,
   parameter bit UP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_chk_w
      $error("dma_cs_counter: W must be at least 1");
   end

   logic [W-1:0] q_next;

   // the parameter picks an incrementing or decrementing variant
   if (UP) begin : g_up
      assign q_next = q + W'(1);
   end else begin : g_down
      assign q_next = q - W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= load_val;
      end else if (step) begin
         q <= q_next;
      end
   end

endmodule

// File: rtl/dma_cs_regs.sv
module dma_cs_regs
   import dma_cs_pkg::*;
#(
   parameter int DEV_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [2:0]          reg_addr,
   input  logic [CTRL_W-1:0]   ctrl_bits,
   input  logic [DEV_W-1:0]    dev_val,
   input  logic                busy,
   input  logic                done,
   output logic                launch,
   output logic                ld_mem,
   output logic                ld_cnt,
   output dir_e                dir,
   output mode_e               mode,
   output logic [DEV_W-1:0]    dev_sel,
   output logic                irq
);

   logic idle_wr;
   logic irq_clr;

   // setup writes only land while the channel is idle
   assign idle_wr = reg_wr && !busy;
   assign launch  = idle_wr && (reg_addr == REG_CTRL) && ctrl_bits[CTRL_GO];
   assign ld_mem  = idle_wr && (reg_addr == REG_MEM);
   assign ld_cnt  = idle_wr && (reg_addr == REG_CNT);
   assign irq_clr = reg_wr && (reg_addr == REG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir     <= DIR_DEV2MEM;
         mode    <= MODE_STEAL;
         dev_sel <= '0;
      end else if (idle_wr) begin
         if (reg_addr == REG_CTRL) begin
            dir  <= dir_e'(ctrl_bits[CTRL_DIR]);
            mode <= mode_e'(ctrl_bits[CTRL_BURST]);
         end
         if (reg_addr == REG_DEV) begin
            dev_sel <= dev_val;
         end
      end
   end

   // completion outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (done) begin
         irq <= 1'b1;
      end else if (irq_clr) begin
         irq <= 1'b0;
      end
   end

   p_irq_keep_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   p_done_sets_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> irq);

endmodule

// File: rtl/dma_cs_xfer.sv
module dma_cs_xfer
   import dma_cs_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int MADDR_W = 16,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic               ld_mem,
   input  logic               ld_cnt,
   input  logic [MADDR_W-1:0] mem_val,
   input  logic [CNT_W-1:0]   cnt_val,
   input  dir_e               dir,
   input  mode_e              mode,
   input  logic               granted,
   input  logic               dev_rdy,
   input  logic [DATA_W-1:0]  dev_rdata,
   input  logic               dev_room,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               busy,
   output logic               want_bus,
   output logic               done,
   output logic               mem_en,
   output logic               mem_we,
   output logic [MADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               dev_ack,
   output logic               dev_wr,
   output logic [DATA_W-1:0]  dev_wdata
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             peer_ok;
   logic             move;
   logic             last;
   logic [CNT_W-1:0] remain;

   assign peer_ok  = (dir == DIR_MEM2DEV) ? dev_room : dev_rdy;
   assign want_bus = busy && ((mode == MODE_BURST) || peer_ok);
   assign move     = busy && peer_ok && granted;
   assign last     = (remain == CNT_ONE);
   assign done     = (launch && (remain == '0)) || (move && last);

   dma_cs_counter #(.W(MADDR_W), .UP(1'b1)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_mem),
      .load_val (mem_val),
      .step     (move),
      .q        (mem_addr)
   );

   dma_cs_counter #(.W(CNT_W), .UP(1'b0)) u_left (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_cnt),
      .load_val (cnt_val),
      .step     (move),
      .q        (remain)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else if (launch && (remain != '0)) begin
         busy <= 1'b1;
      end else if (move && last) begin
         busy <= 1'b0;
      end
   end

   assign mem_en    = move;
   assign mem_we    = move && (dir == DIR_DEV2MEM);
   assign mem_wdata = dev_rdata;
   assign dev_ack   = move && (dir == DIR_DEV2MEM);
   assign dev_wr    = move && (dir == DIR_MEM2DEV);
   assign dev_wdata = mem_rdata;

   p_ptr_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      move |=> (mem_addr == $past(mem_addr) + MADDR_W'(1)));

   p_cnt_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      move |=> (remain == $past(remain) - CNT_ONE));

   p_no_move_idle_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_en && !dev_ack && !dev_wr));

endmodule

// File: rtl/dma_cs_arb.sv
module dma_cs_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_req,
   input  logic dma_req,
   output logic cpu_gnt,
   output logic dma_gnt
);

   // the engine has absolute priority
   assign dma_gnt = dma_req;
   assign cpu_gnt = cpu_req && !dma_req;

   p_cpu_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !dma_req) |-> cpu_gnt);

endmodule

// File: rtl/dma_cs_engine.sv
module dma_cs_engine
   import dma_cs_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int MADDR_W = 16,
   parameter int CNT_W   = 16,
   parameter int DEV_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [2:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic               busy,
   output logic               irq,
   input  logic               cpu_req,
   output logic               cpu_gnt,
   output logic               dma_gnt,
   output logic               mem_en,
   output logic               mem_we,
   output logic [MADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [DEV_W-1:0]   dev_sel,
   input  logic               dev_rdy,
   input  logic [DATA_W-1:0]  dev_rdata,
   output logic               dev_ack,
   input  logic               dev_room,
   output logic               dev_wr,
   output logic [DATA_W-1:0]  dev_wdata
);

   if (MADDR_W > DATA_W) begin : g_chk_addr
      $error("dma_cs_engine: MADDR_W must not exceed DATA_W");
   end
   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("dma_cs_engine: CNT_W must not exceed DATA_W");
   end
   if (DEV_W > DATA_W || DATA_W < CTRL_W) begin : g_chk_dev
      $error("dma_cs_engine: DEV_W or DATA_W out of range");
   end

   logic  launch, ld_mem, ld_cnt, done, want_bus;
   dir_e  dir;
   mode_e mode;

   dma_cs_regs #(.DEV_W(DEV_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .ctrl_bits (reg_wdata[CTRL_W-1:0]),
      .dev_val   (reg_wdata[DEV_W-1:0]),
      .busy      (busy),
      .done      (done),
      .launch    (launch),
      .ld_mem    (ld_mem),
      .ld_cnt    (ld_cnt),
      .dir       (dir),
      .mode      (mode),
      .dev_sel   (dev_sel),
      .irq       (irq)
   );

   dma_cs_xfer #(.DATA_W(DATA_W), .MADDR_W(MADDR_W), .CNT_W(CNT_W)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .ld_mem    (ld_mem),
      .ld_cnt    (ld_cnt),
      .mem_val   (reg_wdata[MADDR_W-1:0]),
      .cnt_val   (reg_wdata[CNT_W-1:0]),
      .dir       (dir),
      .mode      (mode),
      .granted   (dma_gnt),
      .dev_rdy   (dev_rdy),
      .dev_rdata (dev_rdata),
      .dev_room  (dev_room),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .want_bus  (want_bus),
      .done      (done),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .dev_ack   (dev_ack),
      .dev_wr    (dev_wr),
      .dev_wdata (dev_wdata)
   );

   dma_cs_arb u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_req (cpu_req),
      .dma_req (want_bus),
      .cpu_gnt (cpu_gnt),
      .dma_gnt (dma_gnt)
   );

   p_dma_first_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (dma_gnt && !cpu_gnt));

   p_burst_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode == MODE_BURST) |-> (dma_gnt && !cpu_gnt));

   p_steal_ready_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (dma_gnt && mode == MODE_STEAL) |-> (dir == DIR_MEM2DEV ? dev_room : dev_rdy));

   p_fall_irq_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);

endmodule

// File: tb/tb_dma_cs_engine.sv
`timescale 1ns/1ps
module tb_dma_cs_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        busy, irq, cpu_gnt, dma_gnt, mem_en, mem_we, dev_ack, dev_wr;
   logic        cpu_req = 1'b0;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, dev_wdata;
   logic [3:0]  dev_sel;
   logic        dev_rdy = 1'b0;
   logic        dev_room = 1'b0;
   logic [15:0] dev_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dma_cs_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .busy(busy), .irq(irq), .cpu_req(cpu_req),
      .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .dev_sel(dev_sel), .dev_rdy(dev_rdy), .dev_rdata(dev_rdata),
      .dev_ack(dev_ack), .dev_room(dev_room), .dev_wr(dev_wr),
      .dev_wdata(dev_wdata)
   );

   // memory model with combinational read and a bench preload port
   logic [15:0] bmem [0:255];
   logic        tb_we = 1'b0;
   logic [7:0]  tb_wa = '0;
   logic [15:0] tb_wd = '0;
   assign mem_rdata = bmem[mem_addr[7:0]];
   always @(posedge clk) begin
      if (tb_we) bmem[tb_wa] <= tb_wd;
      else if (mem_en && mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
   end

   // peripheral sink and memory access counter
   logic [15:0] cap [0:15];
   int cap_n = 0;
   int acc_n = 0;
   always @(posedge clk) begin
      if (dev_wr) begin
         cap[cap_n[3:0]] <= dev_wdata;
         cap_n <= cap_n + 1;
      end
      if (mem_en) acc_n <= acc_n + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic preload(input logic [7:0] a, input logic [15:0] d);
      tb_we = 1'b1; tb_wa = a; tb_wd = d;
      @(posedge clk); #1;
      tb_we = 1'b0;
   endtask

   task automatic setup(input logic [3:0] dv, input logic [15:0] ma,
                        input logic [15:0] cnt, input logic [2:0] ctrl);
      wr_reg(3'd1, {12'd0, dv});
      wr_reg(3'd2, ma);
      wr_reg(3'd3, cnt);
      wr_reg(3'd0, {13'd0, ctrl});
   endtask

   task automatic t_reset;
      cpu_req = 1'b1; #1;
      chk("R1 busy", busy, 0);
      chk("R1 irq", irq, 0);
      chk("R1 mem_en", mem_en, 0);
      chk("R1 dma_gnt", dma_gnt, 0);
      chk("R1 cpu_gnt", cpu_gnt, 1);
      cpu_req = 1'b0;
   endtask

   task automatic t_zero_count;
      int a0;
      a0 = acc_n;
      setup(4'd2, 16'h0020, 16'd0, 3'b001);
      chk("R7 irq", irq, 1);
      chk("R7 busy", busy, 0);
      @(posedge clk); #1;
      chk("R7 no access", acc_n, a0);
      wr_reg(3'd4, 16'd0);
      chk("R6 clear", irq, 0);
   endtask

   task automatic t_steal_in;
      setup(4'd5, 16'h0010, 16'd4, 3'b001);
      chk("R2 busy", busy, 1);
      chk("R12 dev_sel", dev_sel, 5);
      for (int k = 0; k < 4; k++) begin
         cpu_req = 1'b1; dev_rdy = 1'b0; #1;
         chk("R10 stall cpu_gnt", cpu_gnt, 1);
         chk("R10 stall dma_gnt", dma_gnt, 0);
         @(posedge clk); #1;
         dev_rdy = 1'b1; dev_rdata = 16'hA000 + 16'(k); #1;
         chk("R9 dma_gnt", dma_gnt, 1);
         chk("R9 cpu_gnt", cpu_gnt, 0);
         chk("R3 mem_we", {mem_en, mem_we, dev_ack}, 3'b111);
         chk("R3 addr", mem_addr, 16'h0010 + 16'(k));
         @(posedge clk); #1;
         dev_rdy = 1'b0;
         if (k < 3) chk("R5 still busy", busy, 1);
      end
      chk("R5 busy", busy, 0);
      chk("R5 irq", irq, 1);
      #1;
      chk("R10 release", cpu_gnt, 1);
      cpu_req = 1'b0;
      for (int k = 0; k < 4; k++) chk("R3 data", bmem[8'h10 + 8'(k)], 16'hA000 + 16'(k));
      wr_reg(3'd4, 16'd0);
   endtask

   task automatic t_burst_out;
      int c0;
      for (int k = 0; k < 3; k++) preload(8'h40 + 8'(k), 16'h5500 + 16'(k));
      c0 = cap_n;
      setup(4'd9, 16'h0040, 16'd3, 3'b111);
      cpu_req = 1'b1; dev_room = 1'b0; #1;
      chk("R11 hold dma_gnt", dma_gnt, 1);
      chk("R11 hold cpu_gnt", cpu_gnt, 0);
      chk("R11 stall no access", mem_en, 0);
      @(posedge clk); #1;
      dev_room = 1'b1; #1;
      chk("R4 read", {mem_en, mem_we, dev_wr}, 3'b101);
      chk("R4 wdata", dev_wdata, 16'h5500);
      repeat (3) begin @(posedge clk); #1; end
      chk("R5 burst busy", busy, 0);
      chk("R11 release", cpu_gnt, 1);
      @(posedge clk); #1;
      dev_room = 1'b0;
      chk("R4 count", cap_n - c0, 3);
      for (int k = 0; k < 3; k++) chk("R4 data", cap[4'(c0 + k)], 16'h5500 + 16'(k));
      cpu_req = 1'b0;
      wr_reg(3'd4, 16'd0);
   endtask

   task automatic t_ignore_busy;
      preload(8'h90, 16'h1234);
      setup(4'd3, 16'h0060, 16'd2, 3'b001);
      wr_reg(3'd2, 16'h0090);
      wr_reg(3'd3, 16'd7);
      wr_reg(3'd1, 16'd12);
      wr_reg(3'd0, 16'h0007);
      chk("R8 dev_sel", dev_sel, 3);
      dev_rdy = 1'b1; dev_rdata = 16'hBEE0; #1;
      chk("R8 dir kept", {mem_en, mem_we}, 2'b11);
      chk("R8 addr kept", mem_addr, 16'h0060);
      @(posedge clk); #1;
      dev_rdata = 16'hBEE1;
      @(posedge clk); #1;
      dev_rdy = 1'b0;
      chk("R8 length kept", busy, 0);
      chk("R8 data", bmem[8'h61], 16'hBEE1);
      chk("R8 untouched", bmem[8'h90], 16'h1234);
      repeat (5) @(posedge clk);
      #1;
      chk("R6 hold", irq, 1);
      wr_reg(3'd4, 16'd0);
      chk("R6 cleared", irq, 0);
   endtask

   task automatic t_clear_collide;
      setup(4'd1, 16'h0070, 16'd1, 3'b001);
      dev_rdy = 1'b1; dev_rdata = 16'hC0DE;
      reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'd0;
      @(posedge clk); #1;
      reg_wr = 1'b0; dev_rdy = 1'b0;
      chk("R6 completion wins", irq, 1);
      chk("R5 single word", busy, 0);
      wr_reg(3'd4, 16'd0);
      chk("R6 clear after", irq, 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_zero_count();
      t_steal_in();
      t_burst_out();
      t_ignore_busy();
      t_clear_collide();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule